// File: doc/BRIEF.md
# SPI Command Frame Encoder

This block builds the command frame that a host sends ahead of every register or memory access on a byte-oriented SPI link. A single start pulse presents an opcode together with a 24-bit address, a 32-bit data word, a 24-bit transfer size, a clockless flag and a CRC-enable flag. The encoder picks the frame layout from the opcode and latches the header bytes. It then hands the bytes one at a time to a downstream SPI shifter over a byte-wide valid/ready link. When CRC is enabled it appends a CRC7 byte that it accumulates while the header bytes leave.

The controller is a four-state machine. `ST_IDLE` waits for a start pulse. On a start with a supported opcode it takes the `go` transition to `ST_SEND`. On an unsupported opcode it takes the `reject` transition to `ST_FAULT`. `ST_SEND` advances one byte per handshake and takes the `last` transition to `ST_DONE` on the handshake of the final byte. `ST_DONE` and `ST_FAULT` each last exactly one cycle and take the `return` transition back to `ST_IDLE`.

Top module: `spi_cmd_framer`

## Requirements
- R1: The supported opcodes are 0xC1, 0xC2, 0xC3, 0xC4, 0xC5, 0xC6, 0xC7, 0xC8, 0xC9, 0xCA and 0xCF. A start with any other opcode raises `err_o` for exactly one cycle, in the cycle after the start. No byte is offered for that start, and the encoder is idle again one cycle later.
- R2: Opcode 0xCA sends the opcode, then address bits 23:16, 15:8 and 7:0. This gives 4 header bytes, and the clockless flag has no effect.
- R3: Opcodes 0xC3 and 0xC4 send the opcode, then address bits 15:8 with bit 7 forced to 1 when `clockless_i` is set, then address bits 7:0. After that, 0xC4 sends one 0x00 byte (4 header bytes) and 0xC3 sends data bits 31:24, 23:16, 15:8 and 7:0 (7 header bytes).
- R4: Opcodes 0xC5 and 0xC6 send the opcode followed by three 0x00 bytes. Opcode 0xCF sends the opcode followed by three 0xFF bytes.
- R5: Opcodes 0xC1 and 0xC2 send the opcode, the 3 address bytes (high first) and then size bits 15:8 and 7:0 (6 header bytes). Opcodes 0xC7 and 0xC8 send the opcode, the 3 address bytes and then size bits 23:16, 15:8 and 7:0 (7 header bytes).
- R6: Opcode 0xC9 sends the opcode, the 3 address bytes (high first) and then data bits 31:24, 23:16, 15:8 and 7:0 (8 header bytes).
- R7: With `crc_en_i` set, one extra byte follows the header. Its bits 7:1 hold the CRC7 of all header bytes, using generator x^7+x^3+1, seed 0x7F, and message bits taken most significant bit first. Its bit 0 is 0.
- R8: With `crc_en_i` clear, the CRC byte is omitted and the frame ends after the last header byte.
- R9: A start pulse is accepted only in `ST_IDLE`. A start during `ST_SEND`, `ST_DONE` or `ST_FAULT` neither alters the frame in flight nor starts a new one.
- R10: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_valid_o` stays high and `tx_data_o` stays unchanged in the next cycle. A byte advances only on a cycle with both high.
- R11: `done_o` is high for exactly one cycle, in the cycle after the handshake of the final byte of the frame. `busy_o` and `tx_valid_o` are low in the cycle after that.
- R12: After reset, `tx_valid_o`, `done_o`, `err_o` and `busy_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to encode one frame |
| opcode_i | input | 8 | Command opcode |
| addr_i | input | 24 | Target address |
| data_i | input | 32 | Write data word |
| size_i | input | 24 | Transfer size for block commands |
| clockless_i | input | 1 | Sets the top bit of the high address byte for internal commands |
| crc_en_i | input | 1 | Append the CRC7 byte |
| tx_data_o | output | 8 | Byte offered to the shifter |
| tx_valid_o | output | 1 | Byte on `tx_data_o` is valid |
| tx_ready_i | input | 1 | Shifter takes the byte |
| busy_o | output | 1 | Encoder is not idle |
| done_o | output | 1 | One-cycle pulse after the final byte |
| err_o | output | 1 | One-cycle pulse for an unsupported opcode |

## Verification
Two things can coincide in one cycle. A new start pulse may arrive while a frame is still streaming, and a downstream stall may hit the very byte whose handshake would end the frame. The bench raises a start with a different opcode and data in the middle of a stalled frame. It then checks, at the ports, that every byte and the CRC match the frame that was first accepted and that no second frame follows. Stall patterns also land on the CRC byte, and the bench judges the done pulse by its cycle distance from that final handshake.

// File: rtl/cfr_pkg.sv
package cfr_pkg;
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 24;
    localparam int DATA_W   = 32;
    localparam int SIZE_W   = 24;
    localparam int CRC_W    = 7;
    localparam int HDR_MAX  = 8;
    localparam int CNT_W    = $clog2(HDR_MAX + 2);
    localparam logic [CRC_W-1:0] CRC_SEED = 7'h7F;
    localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;

    localparam logic [7:0] OP_BLK_WR    = 8'hC1;
    localparam logic [7:0] OP_BLK_RD    = 8'hC2;
    localparam logic [7:0] OP_LOC_WR    = 8'hC3;
    localparam logic [7:0] OP_LOC_RD    = 8'hC4;
    localparam logic [7:0] OP_STOP      = 8'hC5;
    localparam logic [7:0] OP_AGAIN     = 8'hC6;
    localparam logic [7:0] OP_XBLK_WR   = 8'hC7;
    localparam logic [7:0] OP_XBLK_RD   = 8'hC8;
    localparam logic [7:0] OP_WORD_WR   = 8'hC9;
    localparam logic [7:0] OP_WORD_RD   = 8'hCA;
    localparam logic [7:0] OP_RESTART   = 8'hCF;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_DONE,
        ST_FAULT
    } cfr_state_e;

    typedef logic [HDR_MAX-1:0][BYTE_W-1:0] hdr_t;
endpackage

// File: rtl/cfr_crc7.sv
module cfr_crc7
    import cfr_pkg::*;
(
    input  logic [CRC_W-1:0]  crc_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [CRC_W-1:0]  crc_o
);
    always_comb begin
        logic [CRC_W-1:0] c;
        logic             fb;
        c = crc_i;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            fb = c[CRC_W-1] ^ byte_i[i];
            c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        end
        crc_o = c;
    end
endmodule

// File: rtl/cfr_layout.sv
module cfr_layout
    import cfr_pkg::*;
(
    input  logic [7:0]        opcode_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic              clockless_i,
    output hdr_t              hdr_o,
    output logic [CNT_W-1:0]  hdr_len_o,
    output logic              known_o
);
    logic [7:0] loc_hi;

    always_comb begin
        loc_hi    = addr_i[15:8] | {clockless_i, 7'b0};
        hdr_o     = '0;
        hdr_o[0]  = opcode_i;
        hdr_len_o = CNT_W'(4);
        known_o   = 1'b1;
        unique case (opcode_i)
            OP_WORD_RD: begin
                hdr_o[1] = addr_i[23:16];
                hdr_o[2] = addr_i[15:8];
                hdr_o[3] = addr_i[7:0];
            end
            OP_LOC_RD: begin
                hdr_o[1] = loc_hi;
                hdr_o[2] = addr_i[7:0];
                hdr_o[3] = 8'h00;
            end
            OP_LOC_WR: begin
                hdr_o[1]  = loc_hi;
                hdr_o[2]  = addr_i[7:0];
                hdr_o[3]  = data_i[31:24];
                hdr_o[4]  = data_i[23:16];
                hdr_o[5]  = data_i[15:8];
                hdr_o[6]  = data_i[7:0];
                hdr_len_o = CNT_W'(7);
            end
            OP_STOP, OP_AGAIN: begin
                hdr_o[1] = 8'h00;
                hdr_o[2] = 8'h00;
                hdr_o[3] = 8'h00;
            end
            OP_RESTART: begin
                hdr_o[1] = 8'hFF;
                hdr_o[2] = 8'hFF;
                hdr_o[3] = 8'hFF;
            end
            OP_BLK_WR, OP_BLK_RD: begin
                hdr_o[1]  = addr_i[23:16];
                hdr_o[2]  = addr_i[15:8];
                hdr_o[3]  = addr_i[7:0];
                hdr_o[4]  = size_i[15:8];
                hdr_o[5]  = size_i[7:0];
                hdr_len_o = CNT_W'(6);
            end
            OP_XBLK_WR, OP_XBLK_RD: begin
                hdr_o[1]  = addr_i[23:16];
                hdr_o[2]  = addr_i[15:8];
                hdr_o[3]  = addr_i[7:0];
                hdr_o[4]  = size_i[23:16];
                hdr_o[5]  = size_i[15:8];
                hdr_o[6]  = size_i[7:0];
                hdr_len_o = CNT_W'(7);
            end
            OP_WORD_WR: begin
                hdr_o[1]  = addr_i[23:16];
                hdr_o[2]  = addr_i[15:8];
                hdr_o[3]  = addr_i[7:0];
                hdr_o[4]  = data_i[31:24];
                hdr_o[5]  = data_i[23:16];
                hdr_o[6]  = data_i[15:8];
                hdr_o[7]  = data_i[7:0];
                hdr_len_o = CNT_W'(8);
            end
            default: begin
                known_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/spi_cmd_framer.sv
module spi_cmd_framer
    import cfr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [7:0]        opcode_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic              clockless_i,
    input  logic              crc_en_i,
    output logic [7:0]        tx_data_o,
    output logic              tx_valid_o,
    input  logic              tx_ready_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o
);
    cfr_state_e       state_q, state_d;
    hdr_t             lay_hdr, hdr_q;
    logic [CNT_W-1:0] lay_len, len_q, idx_q, last_idx;
    logic             lay_known, crc_en_q;
    logic [CRC_W-1:0] crc_q, crc_nxt;
    logic             beat, in_hdr, accept;

    cfr_layout u_layout (
        .opcode_i    (opcode_i),
        .addr_i      (addr_i),
        .data_i      (data_i),
        .size_i      (size_i),
        .clockless_i (clockless_i),
        .hdr_o       (lay_hdr),
        .hdr_len_o   (lay_len),
        .known_o     (lay_known)
    );

    cfr_crc7 u_crc (
        .crc_i  (crc_q),
        .byte_i (hdr_q[idx_q[2:0]]),
        .crc_o  (crc_nxt)
    );

    assign in_hdr   = (idx_q < len_q);
    assign last_idx = len_q - CNT_W'(1) + CNT_W'(crc_en_q);
    assign beat     = (state_q == ST_SEND) && tx_ready_i;
    assign accept   = (state_q == ST_IDLE) && start_i && lay_known;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = lay_known ? ST_SEND : ST_FAULT;
            end
            ST_SEND: begin
                if (beat && (idx_q == last_idx)) state_d = ST_DONE;
            end
            ST_DONE:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr_q    <= '0;
            len_q    <= CNT_W'(4);
            crc_en_q <= 1'b0;
            idx_q    <= '0;
            crc_q    <= CRC_SEED;
        end else if (accept) begin
            hdr_q    <= lay_hdr;
            len_q    <= lay_len;
            crc_en_q <= crc_en_i;
            idx_q    <= '0;
            crc_q    <= CRC_SEED;
        end else if (beat) begin
            idx_q <= idx_q + CNT_W'(1);
            if (in_hdr) crc_q <= crc_nxt;
        end
    end

    // outputs
    always_comb begin
        tx_valid_o = (state_q == ST_SEND);
        tx_data_o  = in_hdr ? hdr_q[idx_q[2:0]] : {crc_q, 1'b0};
        busy_o     = (state_q != ST_IDLE);
        done_o     = (state_q == ST_DONE);
        err_o      = (state_q == ST_FAULT);
    end
endmodule

// File: rtl/cfr_checker.sv
module cfr_checker
    import cfr_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic [7:0] tx_data_o,
    input logic       tx_valid_o,
    input logic       tx_ready_i,
    input logic       busy_o,
    input logic       done_o,
    input logic       err_o
);
    logic [3:0] beats;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       beats <= '0;
        else if (done_o)                  beats <= '0;
        else if (tx_valid_o && tx_ready_i) beats <= beats + 4'd1;
    end

    a_r10_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));

    a_r11_done_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(tx_valid_o && tx_ready_i));

    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o && !busy_o && !tx_valid_o);

    a_r1_err_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(start_i) && !tx_valid_o);

    a_r1_err_returns_idle: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o && !busy_o);

    a_r8_frame_len: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (beats >= 4'd4) && (beats <= 4'd9));

    a_r12_valid_busy: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o |-> busy_o);
endmodule

bind spi_cmd_framer cfr_checker u_chk (.*);

// File: tb/sim_spi_cmd_framer.sv
module sim_spi_cmd_framer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  opcode_i = '0;
    logic [23:0] addr_i = '0;
    logic [31:0] data_i = '0;
    logic [23:0] size_i = '0;
    logic        clockless_i = 1'b0;
    logic        crc_en_i = 1'b0;
    logic [7:0]  tx_data_o;
    logic        tx_valid_o;
    logic        tx_ready_i = 1'b0;
    logic        busy_o, done_o, err_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    spi_cmd_framer u0 (.*);

    typedef struct packed {
        logic [7:0]  op;
        logic [23:0] addr;
        logic [31:0] data;
        logic [23:0] size;
        logic        ck;
        logic        crc;
        logic [3:0]  len;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{8'hC1, 24'h123456, 32'h0,        24'h00ABCD, 1'b0, 1'b1, 4'd7},
        '{8'hC2, 24'hA0B0C0, 32'h0,        24'h000102, 1'b0, 1'b0, 4'd6},
        '{8'hC3, 24'h000024, 32'hDEADBEEF, 24'h0,      1'b1, 1'b1, 4'd8},
        '{8'hC4, 24'h00E824, 32'h0,        24'h0,      1'b0, 1'b1, 4'd5},
        '{8'hC5, 24'h777777, 32'h55555555, 24'h0,      1'b0, 1'b1, 4'd5},
        '{8'hC6, 24'h0,      32'h0,        24'h0,      1'b0, 1'b0, 4'd4},
        '{8'hC7, 24'h0F1E2D, 32'h0,        24'h012345, 1'b0, 1'b1, 4'd8},
        '{8'hC8, 24'hFFFFFF, 32'h0,        24'hFEDCBA, 1'b0, 1'b0, 4'd7},
        '{8'hC9, 24'h001000, 32'h11223344, 24'h0,      1'b0, 1'b1, 4'd9},
        '{8'hCA, 24'h001000, 32'h0,        24'h0,      1'b1, 1'b1, 4'd5},
        '{8'hCF, 24'h0,      32'h0,        24'h0,      1'b0, 1'b1, 4'd5},
        '{8'hC3, 24'h00ABCD, 32'h01020304, 24'h0,      1'b0, 1'b0, 4'd7}
    };

    logic [6:0] ctab [256];
    logic [7:0] exp_b [9];
    int         exp_n;

    function automatic string tag_of(input logic [7:0] op);
        case (op)
            8'hCA:               return "R2";
            8'hC3, 8'hC4:        return "R3";
            8'hC5, 8'hC6, 8'hCF: return "R4";
            8'hC9:               return "R6";
            default:             return "R5";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, expv);
        end
    endtask

    // CRC by polynomial division of one byte, zero start state
    task automatic build_ctab();
        for (int x = 0; x < 256; x++) begin
            logic [14:0] v;
            v = 15'(x) << 7;
            for (int i = 14; i >= 7; i--)
                if (v[i]) v = v ^ (15'h89 << (i - 7));
            ctab[x] = v[6:0];
        end
    endtask

    task automatic expect_frame(input vec_t v);
        logic [6:0] c;
        logic [7:0] hi;
        int n;
        hi = v.addr[15:8] | (v.ck ? 8'h80 : 8'h00);
        exp_b[0] = v.op;
        n = 4;
        case (v.op)
            8'hCA: begin exp_b[1] = v.addr[23:16]; exp_b[2] = v.addr[15:8]; exp_b[3] = v.addr[7:0]; end
            8'hC4: begin exp_b[1] = hi; exp_b[2] = v.addr[7:0]; exp_b[3] = 8'h00; end
            8'hC3: begin
                exp_b[1] = hi; exp_b[2] = v.addr[7:0];
                for (int k = 0; k < 4; k++) exp_b[3+k] = v.data[31-8*k -: 8];
                n = 7;
            end
            8'hC5, 8'hC6: begin exp_b[1] = 8'h00; exp_b[2] = 8'h00; exp_b[3] = 8'h00; end
            8'hCF: begin exp_b[1] = 8'hFF; exp_b[2] = 8'hFF; exp_b[3] = 8'hFF; end
            8'hC1, 8'hC2: begin
                for (int k = 0; k < 3; k++) exp_b[1+k] = v.addr[23-8*k -: 8];
                exp_b[4] = v.size[15:8]; exp_b[5] = v.size[7:0];
                n = 6;
            end
            8'hC7, 8'hC8: begin
                for (int k = 0; k < 3; k++) exp_b[1+k] = v.addr[23-8*k -: 8];
                for (int k = 0; k < 3; k++) exp_b[4+k] = v.size[23-8*k -: 8];
                n = 7;
            end
            default: begin
                for (int k = 0; k < 3; k++) exp_b[1+k] = v.addr[23-8*k -: 8];
                for (int k = 0; k < 4; k++) exp_b[4+k] = v.data[31-8*k -: 8];
                n = 8;
            end
        endcase
        if (v.crc) begin
            c = 7'h7F;
            for (int k = 0; k < n; k++) c = ctab[{c, 1'b0} ^ exp_b[k]];
            exp_b[n] = {c, 1'b0};
            n++;
        end
        exp_n = n;
    endtask

    // Drives one frame; mode selects the ready pattern, poke injects a start mid-frame
    task automatic run_frame(input vec_t v, input int mode, input bit poke);
        logic [7:0] rx [9];
        int got, cyc, last_hs;
        bit prev_stall;
        logic [7:0] prev_data;
        string t;
        t = tag_of(v.op);
        expect_frame(v);
        @(negedge clk);
        start_i = 1'b1; opcode_i = v.op; addr_i = v.addr; data_i = v.data;
        size_i = v.size; clockless_i = v.ck; crc_en_i = v.crc;
        @(negedge clk);
        start_i = 1'b0;
        got = 0; cyc = 0; last_hs = -10; prev_stall = 0; prev_data = '0;
        while (!done_o && cyc < 60) begin
            tx_ready_i = (mode == 0) ? 1'b1 : ((cyc % 3) != (mode - 1));
            if (poke && (cyc == 2 || cyc == 3)) begin
                start_i = 1'b1; opcode_i = 8'hC9; addr_i = 24'h5A5A5A;
                data_i = 32'hCAFEF00D; crc_en_i = ~v.crc;
            end else begin
                start_i = 1'b0;
            end
            if (prev_stall)
                chk(tx_valid_o && tx_data_o == prev_data, "R10", "held byte", {23'b0, tx_valid_o, tx_data_o}, {24'h1, prev_data});
            if (tx_valid_o && tx_ready_i) begin
                if (got < 9) rx[got] = tx_data_o;
                got++;
                last_hs = cyc;
            end
            prev_stall = tx_valid_o && !tx_ready_i;
            prev_data  = tx_data_o;
            @(negedge clk);
            cyc++;
        end
        start_i = 1'b0;
        tx_ready_i = 1'b0;
        chk(done_o && cyc == last_hs + 1, "R11", "done one cycle after last beat", cyc, last_hs + 1);
        chk(got == exp_n && got == int'(v.len), v.crc ? t : "R8", "frame length", got, exp_n);
        if (poke) chk(got == exp_n, "R9", "length with start while busy", got, exp_n);
        for (int k = 0; k < exp_n && k < got; k++) begin
            if (v.crc && k == exp_n - 1)
                chk(rx[k] == exp_b[k] && rx[k][0] == 1'b0, "R7", "crc byte", rx[k], exp_b[k]);
            else
                chk(rx[k] == exp_b[k], poke ? "R9" : t, $sformatf("byte %0d", k), rx[k], exp_b[k]);
        end
        @(negedge clk);
        chk(!done_o && !busy_o && !tx_valid_o, "R11", "after done", {done_o, busy_o, tx_valid_o}, 0);
        repeat (3) begin
            @(negedge clk);
            chk(!tx_valid_o, "R9", "no second frame", tx_valid_o, 0);
        end
    endtask

    task automatic run_bad(input logic [7:0] op);
        @(negedge clk);
        start_i = 1'b1; opcode_i = op; crc_en_i = 1'b1; tx_ready_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(err_o && !tx_valid_o && !done_o, "R1", $sformatf("error pulse op %0h", op), {err_o, tx_valid_o, done_o}, 3'b100);
        @(negedge clk);
        chk(!err_o && !busy_o && !tx_valid_o, "R1", "error cleared", {err_o, busy_o, tx_valid_o}, 0);
        @(negedge clk);
        chk(!tx_valid_o, "R1", "nothing sent", tx_valid_o, 0);
        tx_ready_i = 1'b0;
    endtask

    initial begin
        build_ctab();
        repeat (3) @(negedge clk);
        chk(!tx_valid_o && !done_o && !err_o && !busy_o, "R12", "in reset", {tx_valid_o, done_o, err_o, busy_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!tx_valid_o && !done_o && !err_o && !busy_o, "R12", "after reset", {tx_valid_o, done_o, err_o, busy_o}, 0);

        for (int i = 0; i < NV; i++) run_frame(VECS[i], i % 4, 1'b0);

        // clockless flag must be ignored by the word read (R2) and applied by internal read (R3)
        run_frame('{8'hCA, 24'h00FF00, 32'h0, 24'h0, 1'b1, 1'b0, 4'd4}, 1, 1'b0);
        run_frame('{8'hC4, 24'h000012, 32'h0, 24'h0, 1'b1, 1'b1, 4'd5}, 0, 1'b0);
        // start while streaming and stalled on the last byte (R9, R10)
        run_frame(VECS[8], 3, 1'b1);
        run_frame(VECS[5], 2, 1'b1);

        run_bad(8'hC0);
        run_bad(8'hCB);
        run_bad(8'h00);
        run_frame(VECS[10], 0, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule